// File: doc/BRIEF.md
# Management Command Response Unit

This block answers management commands posted by software through a small register port. Software first writes a pool identifier byte, then a command verb byte. A verb write is taken as a new command only when its top bit matches the block's current phase bit and no earlier command is still being processed. Verb writes that fail either test are dropped without any effect.

An accepted command is one of two kinds. An acquire takes buffers from a per-pool counter. A query reports the counter's value. Any malformed command produces an invalid-command code. The block holds two response slots and uses them in alternation. The result goes into the slot selected by the phase bit. The phase then flips and the other slot's verb is cleared to zero. Software therefore polls a single verb byte and knows a result has landed when that byte becomes non-zero with the expected top bit.

The per-pool counters are a model of buffer counts only. No buffer addresses are stored. Every pool starts with the same parameterised count.

Top module: `mcr_unit`

## Requirements
- R1: After reset the phase bit is 0, so slot 0 is the active slot. The verb and data bytes of both slots read 0x00, and so do the command addresses 0x0 and 0x1. A read issued on one clock edge returns its data after that edge.
- R2: A write to the command verb address (0x0) starts a command only when bit 7 of the written byte equals the phase bit and the block is idle. Any other verb write has no effect on the slots, the phase or the pool counters.
- R3: Each completed command writes its slot, chosen by the phase bit, and then inverts the phase bit. Slot 0 has its verb at 0x8 and its data at 0x9. Slot 1 has its verb at 0xC and its data at 0xD. Bit 7 of the response verb equals the valid bit of the command.
- R4: When a command completes, the verb byte of the other slot is cleared to 0x00. That byte stays 0x00 until the next command completes into it.
- R5: An acquire uses code 001 in verb bits 6:4 and a requested count of 1 to 8 in bits 3:0. It grants the smaller of the requested count and the pool's current count, and subtracts the grant from the counter. The response verb is 0x10 plus the grant. The data byte holds the remaining count.
- R6: An acquire on a pool whose counter is 0 answers with a grant of 0 (response verb 0x10) and leaves the counter at 0.
- R7: A query uses code 100 in verb bits 6:4. Its response verb is 0x40 and its data byte holds the pool's current count, which the query leaves unchanged.
- R8: The response verb is 0x60 with data 0x00, and no counter changes, in any of these cases: a code other than 001 or 100, an acquire count of 0 or above 8, or a pool identifier above 63.
- R9: The response slot is written exactly RESP_LAT clock edges after the edge that accepts the command. Verb writes that arrive while a command is in progress are dropped.
- R10: After reset every pool counter holds INIT_COUNT (default 10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte address for reads and writes |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rdata | output | 8 | Registered read data |

## Verification
The stimulus mixes several kinds of acquire. Some requests fit inside the pool count and some exceed it. One drains a pool to empty, and the next acquire then finds the pool empty. Comparing the granted count against the remaining count tells a correct minimum apart from a plain subtraction or a saturation at the wrong point. Queries of touched and untouched pools show whether counters persist and whether each pool keeps its own count. Each kind of malformed command is followed by a query of the same pool, which confirms that the invalid path left the counter alone. Three further cases are checked apart: a wrong-phase write, a write while busy, and a read one cycle before and one cycle after the expected completion. These separate a block that ignores its phase or busy gating from one that is merely slow or early.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  localparam int ADDR_W      = 4;
  localparam int SLOT_BASE   = 8;
  localparam int SLOT_STRIDE = 4;
  localparam int SLOTS       = 2;

  localparam logic [ADDR_W-1:0] A_CMD_VERB = 4'h0;
  localparam logic [ADDR_W-1:0] A_CMD_POOL = 4'h1;

  localparam logic [2:0] OP_ACQ = 3'b001;
  localparam logic [2:0] OP_QRY = 3'b100;
  localparam logic [2:0] OP_BAD = 3'b110;

  typedef struct packed {
    logic [6:0] verb_lo;
    logic [7:0] aux;
  } resp_t;
endpackage

// File: rtl/mcr_decode.sv
module mcr_decode #(
  parameter int POOLS   = 64,
  parameter int MAX_REQ = 8,
  parameter int CNT_W   = 8
) (
  input  logic [7:0]       verb,
  input  logic [7:0]       pool_id,
  input  logic [CNT_W-1:0] avail,
  output mcr_pkg::resp_t   resp,
  output logic             upd,
  output logic [CNT_W-1:0] new_cnt
);
  import mcr_pkg::*;

  logic [2:0]       op;
  logic [3:0]       req;
  logic             pool_ok;
  logic             req_ok;
  logic [CNT_W-1:0] req_c;
  logic [CNT_W-1:0] grant;

  always_comb begin
    op      = verb[6:4];
    req     = verb[3:0];
    pool_ok = (int'(pool_id) < POOLS);
    req_ok  = (req != 4'd0) && (int'(req) <= MAX_REQ);
    req_c   = CNT_W'(req);
    grant   = (req_c < avail) ? req_c : avail;

    resp.verb_lo = {OP_BAD, 4'h0};
    resp.aux     = 8'h00;
    upd          = 1'b0;
    new_cnt      = avail;

    if (op == OP_ACQ && pool_ok && req_ok) begin
      new_cnt      = avail - grant;
      resp.verb_lo = {OP_ACQ, grant[3:0]};
      resp.aux     = 8'(avail - grant);
      upd          = 1'b1;
    end else if (op == OP_QRY && pool_ok) begin
      resp.verb_lo = {OP_QRY, 4'h0};
      resp.aux     = 8'(avail);
    end
  end
endmodule

// File: rtl/mcr_pool_ram.sv
module mcr_pool_ram #(
  parameter int POOLS      = 64,
  parameter int CNT_W      = 8,
  parameter int INIT_COUNT = 10,
  localparam int POOL_W    = $clog2(POOLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [POOL_W-1:0] rd_addr,
  input  logic              we,
  input  logic [POOL_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  rd_data
);
  // Count storage carries no reset so it maps onto block RAM; a flag
  // per pool marks entries written since reset.
  logic [CNT_W-1:0] mem [POOLS];
  logic [CNT_W-1:0] mem_q;
  logic [POOLS-1:0] touched;
  logic             touched_q;

  always_ff @(posedge clk) begin
    if (we) mem[wr_addr] <= wr_data;
    if (rd_en) mem_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      touched   <= '0;
      touched_q <= 1'b0;
    end else begin
      if (we) touched[wr_addr] <= 1'b1;
      if (rd_en) touched_q <= touched[rd_addr];
    end
  end

  assign rd_data = touched_q ? mem_q : CNT_W'(INIT_COUNT);
endmodule

// File: rtl/mcr_resp_regs.sv
module mcr_resp_regs (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            done,
  input  logic                            phase,
  input  mcr_pkg::resp_t                  resp,
  input  logic                            rd_en,
  input  logic [mcr_pkg::ADDR_W-1:0]      rd_addr,
  output logic [7:0]                      rd_data,
  output logic [mcr_pkg::SLOTS-1:0][7:0]  slot_verb
);
  import mcr_pkg::*;

  logic [SLOTS-1:0][7:0] slot_aux;
  logic [7:0]            rd_mux;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_verb[s] <= 8'h00;
        slot_aux[s]  <= 8'h00;
      end else if (done) begin
        if (phase == 1'(s)) begin
          slot_verb[s] <= {phase, resp.verb_lo};
          slot_aux[s]  <= resp.aux;
        end else begin
          slot_verb[s] <= 8'h00;
        end
      end
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    for (int s = 0; s < SLOTS; s++) begin
      if (rd_addr == ADDR_W'(SLOT_BASE + SLOT_STRIDE * s)) rd_mux = slot_verb[s];
      if (rd_addr == ADDR_W'(SLOT_BASE + SLOT_STRIDE * s + 1)) rd_mux = slot_aux[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= 8'h00;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/mcr_unit.sv
module mcr_unit #(
  parameter int POOLS      = 64,
  parameter int MAX_REQ    = 8,
  parameter int CNT_W      = 8,
  parameter int INIT_COUNT = 10,
  parameter int RESP_LAT   = 3,
  localparam int ADDR_W    = mcr_pkg::ADDR_W,
  localparam int POOL_W    = $clog2(POOLS),
  localparam int LAT_W     = $clog2(RESP_LAT) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              rd_en,
  output logic [7:0]        rdata
);
  import mcr_pkg::*;

  logic                   phase;
  logic                   busy;
  logic [LAT_W-1:0]       cnt;
  logic [7:0]             cmd_verb_q;
  logic [7:0]             cmd_pool_q;
  logic [7:0]             pool_reg;
  logic                   accept;
  logic                   done;
  logic [CNT_W-1:0]       avail;
  logic [CNT_W-1:0]       new_cnt;
  logic                   upd;
  resp_t                  resp;
  logic [SLOTS-1:0][7:0]  slot_verb;

  assign accept = wr_en && (addr == A_CMD_VERB) && (wdata[7] == phase) && !busy;
  assign done   = busy && (cnt == LAT_W'(RESP_LAT - 1));

  always_ff @(posedge clk) begin
    if (rst) pool_reg <= 8'h00;
    else if (wr_en && addr == A_CMD_POOL) pool_reg <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= 1'b0;
      busy       <= 1'b0;
      cnt        <= '0;
      cmd_verb_q <= 8'h00;
      cmd_pool_q <= 8'h00;
    end else if (accept) begin
      busy       <= 1'b1;
      cnt        <= '0;
      cmd_verb_q <= wdata;
      cmd_pool_q <= pool_reg;
    end else if (busy) begin
      if (done) begin
        busy  <= 1'b0;
        phase <= ~phase;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  mcr_pool_ram #(
    .POOLS(POOLS), .CNT_W(CNT_W), .INIT_COUNT(INIT_COUNT)
  ) u_ram (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (accept),
    .rd_addr (pool_reg[POOL_W-1:0]),
    .we      (done && upd),
    .wr_addr (cmd_pool_q[POOL_W-1:0]),
    .wr_data (new_cnt),
    .rd_data (avail)
  );

  mcr_decode #(
    .POOLS(POOLS), .MAX_REQ(MAX_REQ), .CNT_W(CNT_W)
  ) u_dec (
    .verb    (cmd_verb_q),
    .pool_id (cmd_pool_q),
    .avail   (avail),
    .resp    (resp),
    .upd     (upd),
    .new_cnt (new_cnt)
  );

  mcr_resp_regs u_resp (
    .clk       (clk),
    .rst       (rst),
    .done      (done),
    .phase     (phase),
    .resp      (resp),
    .rd_en     (rd_en),
    .rd_addr   (addr),
    .rd_data   (rdata),
    .slot_verb (slot_verb)
  );
endmodule

// File: rtl/mcr_unit_chk.sv
module mcr_unit_chk #(
  parameter int MAX_REQ  = 8,
  parameter int RESP_LAT = 3
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            wr_en,
  input logic [mcr_pkg::ADDR_W-1:0]      addr,
  input logic [7:0]                      wdata,
  input logic                            phase,
  input logic                            busy,
  input logic                            done,
  input logic [mcr_pkg::SLOTS-1:0][7:0]  slot_verb,
  input mcr_pkg::resp_t                  resp
);
  import mcr_pkg::*;

  logic verb_wr;
  assign verb_wr = wr_en && (addr == A_CMD_VERB);

  // Independent cycle count since the last accepted command.
  int  since;
  logic running;
  always_ff @(posedge clk) begin
    if (rst) begin
      since   <= 0;
      running <= 1'b0;
    end else if (!busy && verb_wr && wdata[7] == phase) begin
      since   <= 0;
      running <= 1'b1;
    end else if (running) begin
      since <= since + 1;
      if (done) running <= 1'b0;
    end
  end

  assert_ignore_wrong_phase_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && verb_wr && wdata[7] != phase) |=> !busy);

  assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && verb_wr && wdata[7] == phase) |=> busy);

  assert_phase_toggle_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> (phase != $past(phase)));

  assert_phase_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(phase));

  assert_resp_vbit_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> ((phase ? slot_verb[0][7] : slot_verb[1][7]) == ~phase));

  assert_other_slot_zero_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> ((phase ? slot_verb[1] : slot_verb[0]) == 8'h00));

  assert_grant_limit_R5: assert property (@(posedge clk) disable iff (rst)
    (done && resp.verb_lo[6:4] == OP_ACQ) |-> (int'(resp.verb_lo[3:0]) <= MAX_REQ));

  assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (running && since == RESP_LAT - 1));
endmodule

bind mcr_unit mcr_unit_chk #(.MAX_REQ(MAX_REQ), .RESP_LAT(RESP_LAT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .addr      (addr),
  .wdata     (wdata),
  .phase     (phase),
  .busy      (busy),
  .done      (done),
  .slot_verb (slot_verb),
  .resp      (resp)
);

// File: tb/sim_mcr_unit.sv
module sim_mcr_unit;
  localparam int LAT = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  int   checks = 0;
  int   errors = 0;
  logic ph = 1'b0;
  logic [7:0] v;

  always #5 clk = ~clk;

  mcr_unit #(.RESP_LAT(LAT)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rd_en(rd_en), .rdata(rdata)
  );

  // {pool, command verb bits 6:0, expected verb bits 6:0, expected data}
  localparam logic [31:0] VEC [13] = '{
    32'h05_18_18_02,  // R5 acquire 8 of 10
    32'h05_14_12_00,  // R5 request 4, only 2 left
    32'h05_11_10_00,  // R6 empty pool
    32'h05_40_40_00,  // R7 query drained pool
    32'h06_40_40_0A,  // R10 untouched pool
    32'h3F_13_13_07,  // R5 highest pool id
    32'h40_11_60_00,  // R8 pool id 64
    32'h06_10_60_00,  // R8 count 0
    32'h06_19_60_00,  // R8 count 9
    32'h06_20_60_00,  // R8 unknown code
    32'h06_40_40_0A,  // R8 counter untouched by invalid commands
    32'h00_15_15_05,  // R5 pool 0
    32'hC8_40_60_00   // R8 query with pool id 200
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  function automatic logic [3:0] vaddr(input logic p);
    return p ? 4'hC : 4'h8;
  endfunction

  task automatic issue(input logic [7:0] pool, input logic [6:0] lo);
    wr(4'h1, pool);
    wr(4'h0, {ph, lo});
    repeat (LAT) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(4'h8, v); check("R1 slot0 verb", v, 8'h00);
    rd(4'hC, v); check("R1 slot1 verb", v, 8'h00);
    rd(4'h9, v); check("R1 slot0 data", v, 8'h00);
    rd(4'h0, v); check("R1 command verb address", v, 8'h00);

    // Vector walk: R3 slot choice and valid bit, R4 other slot zero
    for (int i = 0; i < 13; i++) begin
      issue(VEC[i][31:24], VEC[i][22:16]);
      rd(vaddr(ph), v);       check("R3/R5/R7/R8 verb", v, {ph, VEC[i][14:8]});
      rd(vaddr(ph) + 4'h1, v); check("R5/R7/R8 data", v, VEC[i][7:0]);
      rd(vaddr(~ph), v);      check("R4 other slot verb", v, 8'h00);
      ph = ~ph;
    end

    // R9 exact latency: one edge early still zero, then the result
    wr(4'h1, 8'h06);
    wr(4'h0, {ph, 7'h40});
    repeat (LAT - 1) @(negedge clk);
    rd(vaddr(ph), v); check("R9 before completion", v, 8'h00);
    rd(vaddr(ph), v); check("R9 at completion", v, {ph, 7'h40});
    ph = ~ph;

    // R2 wrong phase write is ignored
    wr(4'h1, 8'h00);
    wr(4'h0, {~ph, 7'h11});
    repeat (LAT + 2) @(negedge clk);
    rd(vaddr(ph), v); check("R2 wrong phase no response", v, 8'h00);
    issue(8'h00, 7'h40);
    rd(vaddr(ph), v); check("R2 phase unchanged", v, {ph, 7'h40});
    rd(vaddr(ph) + 4'h1, v); check("R2 pool 0 count unchanged", v, 8'h05);
    ph = ~ph;

    // R9 verb write while busy is dropped
    wr(4'h1, 8'h00);
    wr(4'h0, {ph, 7'h12});
    wr(4'h0, {ph, 7'h13});
    repeat (LAT) @(negedge clk);
    rd(vaddr(ph), v); check("R9 first command result", v, {ph, 7'h12});
    rd(vaddr(ph) + 4'h1, v); check("R9 first command data", v, 8'h03);
    ph = ~ph;
    repeat (LAT + 2) @(negedge clk);
    rd(vaddr(ph), v); check("R9 busy write not replayed", v, 8'h00);
    issue(8'h00, 7'h40);
    rd(vaddr(ph) + 4'h1, v); check("R9 pool 0 count after busy write", v, 8'h03);
    ph = ~ph;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule